// File: doc/BRIEF.md
# Keyed Slow-Clock Source Selector

This block picks the source of a slow timekeeping clock. It chooses between a free-running internal oscillator and an external crystal clock. Both sources arrive as single-cycle enable pulses in the system clock domain. The block produces a clock-enable pulse stream at the chosen rate. When the internal source is chosen, its pulses are divided by a programmable factor of P+1. The external source passes straight through, and the prescaler does not apply to it. A second output copies the selected stream to an external clock pin, but only when its output gate is open.

Three registers sit behind a simple write port and a combinational read port. The control register holds the source choice. A write to it is accepted only when the upper half of the written word carries the unlock key. The prescaler register and the gate register can be written without a key. Whenever the division factor or the source changes, the divider starts again from zero. The first divided pulse after such a change therefore always comes a full period later.

Top module: `slow_clk_sel`

## Requirements
- R1: A write to the control register (word index 0) whose bits [31:16] differ from 0x16AA leaves the source selection unchanged.
- R2: A control write with bits [31:16] equal to 0x16AA loads bit 0 as the source: 1 selects the external pulses and 0 selects the internal pulses.
- R3: With the internal source selected, tick_o pulses on every (P+1)-th internal pulse, where P is the 5-bit value in bits [4:0] of the prescaler register (word index 1). The range of P is 0 to 31.
- R4: With the external source selected, tick_o repeats every external pulse, whatever the value of P.
- R5: pin_tick_o equals the selected pulse stream while bit 0 of the gate register (word index 2) is 1, and stays 0 while that bit is 0.
- R6: The read port returns the following values. Index 0 returns the selection in bit 0, and the key field and all other bits read as 0. Index 1 returns P in bits [4:0]. Index 2 returns the gate in bit 0. Index 3 returns 0.
- R7: The divider count restarts at zero when P changes value or the selection changes, so the first internal-mode pulse after the change comes after exactly P+1 internal pulses.
- R8: After reset, the internal source is selected, P is 0, the gate is closed, and both outputs are 0.
- R9: tick_o and pin_tick_o appear one clock after the input pulse that causes them. A pulse arriving in the same cycle as a register write is processed with the settings in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| int_tick_i | input | 1 | One-cycle pulse per internal oscillator period |
| ext_tick_i | input | 1 | One-cycle pulse per external crystal period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Word index of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Word index of the read |
| rd_data_o | output | 32 | Read data (combinational) |
| tick_o | output | 1 | Slow clock enable at the selected rate |
| pin_tick_o | output | 1 | Gated copy for the external clock pin |

## Verification
The assertions assume that the source pulses are already synchronous to the system clock, one cycle wide, and that a write carries one word to one index per cycle. The stimulus drives the pulse inputs and the write port only on falling edges, one operation per cycle. This covers bursts, sparse random pulses and back-to-back pulses. It also includes a prescaler change in the middle of a count and source switches in the same cycle as a pulse. A behavioural model in the bench predicts both outputs and the read data each cycle.

// File: rtl/slow_clk_sel_pkg.sv
package slow_clk_sel_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned KEY_W  = 16;
  localparam int unsigned IDX_W  = 2;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h16AA;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL  = 2'd0,
    IDX_PRESC = 2'd1,
    IDX_GATE  = 2'd2,
    IDX_NONE  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/slow_src_regs.sv
module slow_src_regs
  import slow_clk_sel_pkg::*;
#(
  parameter int unsigned PRE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sel_ext,
  output logic [PRE_W-1:0]  pre_val,
  output logic              gate_en,
  output logic              restart
);
  logic             sel_q, sel_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             gate_q, gate_d;
  logic             key_ok;

  assign key_ok = (wr_data[DATA_W-1 -: KEY_W] == UNLOCK_KEY);

  // next-state decode of the write port
  always_comb begin
    sel_d  = sel_q;
    pre_d  = pre_q;
    gate_d = gate_q;
    if (wr_en) begin
      case (reg_idx_e'(wr_addr))
        IDX_CTRL:  if (key_ok) sel_d = wr_data[0];
        IDX_PRESC: pre_d  = wr_data[PRE_W-1:0];
        IDX_GATE:  gate_d = wr_data[0];
        default:   ;
      endcase
    end
  end

  assign restart = (sel_d != sel_q) || (pre_d != pre_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      pre_q  <= '0;
      gate_q <= 1'b0;
    end else if (wr_en) begin
      sel_q  <= sel_d;
      pre_q  <= pre_d;
      gate_q <= gate_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_idx_e'(rd_addr))
      IDX_CTRL:  rd_data[0] = sel_q;
      IDX_PRESC: rd_data[PRE_W-1:0] = pre_q;
      IDX_GATE:  rd_data[0] = gate_q;
      default:   rd_data = '0;
    endcase
  end

  assign sel_ext = sel_q;
  assign pre_val = pre_q;
  assign gate_en = gate_q;
endmodule

// File: rtl/slow_src_div.sv
module slow_src_div #(
  parameter int unsigned PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_tick,
  input  logic             ext_tick,
  input  logic             sel_ext,
  input  logic [PRE_W-1:0] pre_val,
  input  logic             restart,
  output logic             evt,
  output logic             tick,
  output logic [PRE_W-1:0] cnt
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             hit;
  logic             tick_q;
  logic             cnt_en;

  assign hit    = int_tick && (cnt_q == pre_val);
  assign evt    = sel_ext ? ext_tick : hit;
  assign cnt_en = restart || (!sel_ext && int_tick);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (hit)  cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= evt;
  end

  assign tick = tick_q;
  assign cnt  = cnt_q;
endmodule

// File: rtl/slow_src_gate.sv
module slow_src_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic gate_en,
  output logic pin_tick
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= evt & gate_en;
  end

  assign pin_tick = pin_q;
endmodule

// File: rtl/slow_clk_sel.sv
module slow_clk_sel
  import slow_clk_sel_pkg::*;
#(
  parameter int unsigned PRE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_tick_i,
  input  logic              ext_tick_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tick_o,
  output logic              pin_tick_o
);
  logic             rst_meta, rst_sync;
  logic             sel_ext, gate_en, restart, evt;
  logic [PRE_W-1:0] pre_val, div_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  slow_src_regs #(.PRE_W(PRE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .rd_addr (rd_addr_i),
    .rd_data (rd_data_o),
    .sel_ext (sel_ext),
    .pre_val (pre_val),
    .gate_en (gate_en),
    .restart (restart)
  );

  slow_src_div #(.PRE_W(PRE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync),
    .int_tick (int_tick_i),
    .ext_tick (ext_tick_i),
    .sel_ext  (sel_ext),
    .pre_val  (pre_val),
    .restart  (restart),
    .evt      (evt),
    .tick     (tick_o),
    .cnt      (div_cnt)
  );

  slow_src_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_sync),
    .evt      (evt),
    .gate_en  (gate_en),
    .pin_tick (pin_tick_o)
  );
endmodule

// File: rtl/slow_clk_sel_chk.sv
module slow_clk_sel_chk
  import slow_clk_sel_pkg::*;
#(
  parameter int unsigned PRE_W = 5
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              int_tick_i,
  input logic              ext_tick_i,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              tick_o,
  input logic              pin_tick_o,
  input logic              sel_ext,
  input logic              gate_en,
  input logic [PRE_W-1:0]  pre_val,
  input logic [PRE_W-1:0]  div_cnt
);
  AST_BAD_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en_i && wr_addr_i == IDX_CTRL && wr_data_i[DATA_W-1 -: KEY_W] != UNLOCK_KEY)
      |=> (sel_ext == $past(sel_ext))); // R1

  AST_EXT_PASSES: assert property (@(posedge clk) disable iff (!rst_ok)
    sel_ext |=> (tick_o == $past(ext_tick_i))); // R4

  AST_INT_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_ok)
    (!sel_ext && !int_tick_i) |=> !tick_o); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ok)
    div_cnt <= pre_val); // R3

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_ok)
    !gate_en |=> !pin_tick_o); // R5

  AST_PRESC_RESTART: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_en_i && wr_addr_i == IDX_PRESC && wr_data_i[PRE_W-1:0] != pre_val)
      |=> (div_cnt == '0)); // R7
endmodule

bind slow_clk_sel slow_clk_sel_chk #(.PRE_W(PRE_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync),
  .int_tick_i (int_tick_i),
  .ext_tick_i (ext_tick_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .tick_o     (tick_o),
  .pin_tick_o (pin_tick_o),
  .sel_ext    (sel_ext),
  .gate_en    (gate_en),
  .pre_val    (pre_val),
  .div_cnt    (div_cnt)
);

// File: tb/slow_clk_sel_bench.sv
module slow_clk_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        int_tick, ext_tick, wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        tick, pin_tick;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  int m_sel = 0, m_pre = 0, m_gate = 0, m_cnt = 0, m_tick = 0, m_pin = 0;

  always #2 clk = ~clk;

  slow_clk_sel u_slow_clk_sel (
    .clk(clk), .rst_n(rst_n), .int_tick_i(int_tick), .ext_tick_i(ext_tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .tick_o(tick), .pin_tick_o(pin_tick)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_sel;
      2'd1:    return m_pre;
      2'd2:    return m_gate;
      default: return 0;
    endcase
  endfunction

  // one clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic cyc(input bit it, input bit et, input bit we, input logic [1:0] wa,
                     input logic [31:0] wd, input logic [1:0] ra, input string tag);
    int_tick = it; ext_tick = et; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    @(posedge clk);
    begin
      int hit, ev, nsel, npre, ngate;
      hit = (it && m_cnt == m_pre) ? 1 : 0;
      ev  = m_sel ? int'(et) : hit;
      nsel = m_sel; npre = m_pre; ngate = m_gate;
      if (we) begin
        if (wa == 2'd0 && wd[31:16] == 16'h16AA) nsel = int'(wd[0]);
        if (wa == 2'd1) npre = int'(wd[4:0]);
        if (wa == 2'd2) ngate = int'(wd[0]);
      end
      if (m_sel == 0 && it) m_cnt = hit ? 0 : m_cnt + 1;
      if (nsel != m_sel || npre != m_pre) m_cnt = 0;
      m_tick = ev;
      m_pin  = ev & m_gate;
      m_sel = nsel; m_pre = npre; m_gate = ngate;
    end
    @(negedge clk);
    int_tick = 0; ext_tick = 0; wr_en = 0;
    chk(tag, "tick_o", {31'd0, tick}, m_tick);
    chk(tag, "pin_tick_o", {31'd0, pin_tick}, m_pin);
    chk(tag, "rd_data_o", rd_data, exp_rd(ra));
  endtask

  task automatic idle(input int n, input bit it, input bit et, input bit rnd, input logic [1:0] ra, input string tag);
    for (int i = 0; i < n; i++) begin
      bit a, b;
      a = rnd ? bit'($urandom_range(0, 1)) : it;
      b = rnd ? bit'($urandom_range(0, 1)) : et;
      cyc(a, b, 0, 2'd0, 32'd0, ra, tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; int_tick = 0; ext_tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    // R8: reset state visible at every index while held in reset
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      chk("R8", "rd_data_o in reset", rd_data, 32'd0);
    end
    chk("R8", "tick_o in reset", {31'd0, tick}, 32'd0);
    chk("R8", "pin_tick_o in reset", {31'd0, pin_tick}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    idle(4, 0, 0, 0, 2'd0, "R8");

    // R3 with P=0: each internal pulse gives a tick; R4 pulses ignored
    idle(20, 0, 0, 1, 2'd1, "R3");
    // R6/R3: P=3 with random internal pulses
    cyc(0, 0, 1, 2'd1, 32'hFFFF_FFE3, 2'd1, "R6");
    idle(40, 0, 0, 1, 2'd1, "R3");
    // R1: wrong key, selection stays internal
    cyc(0, 0, 1, 2'd0, 32'hABCD_0001, 2'd0, "R1");
    cyc(0, 0, 1, 2'd0, 32'h16AB_0001, 2'd0, "R1");
    idle(6, 1, 1, 0, 2'd0, "R1");
    // R3 maximum prescale
    cyc(0, 0, 1, 2'd1, 32'd31, 2'd1, "R3");
    idle(70, 1, 0, 0, 2'd1, "R3");
    // R7: change P in mid count
    cyc(0, 0, 1, 2'd1, 32'd2, 2'd1, "R7");
    idle(2, 1, 0, 0, 2'd1, "R7");
    cyc(1, 0, 1, 2'd1, 32'd4, 2'd1, "R7");
    idle(12, 1, 0, 0, 2'd1, "R7");
    // same value rewritten: no restart
    idle(2, 1, 0, 0, 2'd1, "R7");
    cyc(1, 0, 1, 2'd1, 32'd4, 2'd1, "R7");
    idle(8, 1, 0, 0, 2'd1, "R7");
    // R2/R9: switch to external with pulses on both inputs in the same cycle
    cyc(1, 1, 1, 2'd0, 32'h16AA_0001, 2'd0, "R9");
    idle(30, 0, 0, 1, 2'd0, "R4");
    // R5: gate open, then closed
    cyc(0, 1, 1, 2'd2, 32'd1, 2'd2, "R5");
    idle(30, 0, 0, 1, 2'd2, "R5");
    cyc(0, 1, 1, 2'd2, 32'd0, 2'd2, "R5");
    idle(10, 0, 0, 1, 2'd2, "R5");
    cyc(0, 0, 1, 2'd2, 32'd1, 2'd2, "R5");
    // R2/R7: back to internal, pulse same cycle, key never reads back (R6)
    cyc(1, 1, 1, 2'd0, 32'h16AA_FFFE, 2'd0, "R7");
    idle(20, 1, 0, 0, 2'd0, "R7");
    idle(20, 0, 0, 1, 2'd3, "R6");
    idle(20, 0, 0, 1, 2'd2, "R5");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule